// File: doc/BRIEF.md
# Multi-Domain Power Gating Sequencer

This controller takes a chip's switchable power domains down and back up in a safe order. For each domain it drives four controls: a one-cycle strobe that saves retention state, an isolation enable, a power switch enable and a one-cycle restore strobe. Each domain returns a power-good acknowledge. The sequencer waits for that acknowledge before it moves to the next step. A top-level FSM or a software shim raises a one-cycle power-down or power-up request for a domain. It reads back a two-bit status code for every domain.

A single engine serves one domain at a time. When several domains are waiting, power-down work goes first, in ascending domain index. Power-up work then runs in descending index, so domains come back in the reverse of the order they went down. After each domain finishes, the engine stays idle for a fixed stagger time before it touches the next one. This spreads the current steps on the rails. Domains named in an always-on mask parameter are never switched. If an acknowledge fails to arrive within the timeout parameter, the sequencer marks that domain with a sticky error, enters a fault state and freezes every control until reset.

Top module: `pgs_top`

## Requirements
- R1: After reset every domain reports status ON (code 0), its switch enable is 1, its isolation is 0, its error bit is 0 and fault is 0.
- R2: On power-down, the domain's save strobe is high for one cycle while the switch is on and isolation is off. Isolation rises in the next cycle, and the switch enable falls at least one cycle after isolation has risen.
- R3: A domain reports OFF (code 2) only after its acknowledge has gone low following the switch-off.
- R4: On power-up, the switch enable rises first. The restore strobe pulses for one cycle only while the acknowledge is high. Isolation is released in the cycle after the restore strobe, and the status then reads ON.
- R5: Status codes are ON=0, GOING_DOWN=1, OFF=2 and GOING_UP=3. An accepted request shows GOING_DOWN or GOING_UP in the cycle after it is sampled.
- R6: A request aimed at an always-on domain (domain 3 by default) causes no save strobe and no switch or isolation change, and its status stays ON.
- R7: A request is ignored if the domain is in transition or already in the requested state.
- R8: Pending power-downs are served in ascending domain index, and pending power-ups in descending index.
- R9: Between one domain's completion and the first control action on the next domain there are at least STAGGER+1 cycles.
- R10: If the acknowledge does not arrive within TIMEOUT cycles, that domain's error bit sets and stays set, and fault goes high. After that no switch or isolation output changes and new requests are ignored until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_dn | input | N_DOM | One-cycle power-down request per domain |
| req_up | input | N_DOM | One-cycle power-up request per domain |
| pwr_ack | input | N_DOM | Power-good acknowledge per domain, 1 = rail up |
| ret_save | output | N_DOM | Retention save strobe |
| iso_en | output | N_DOM | Isolation enable |
| sw_en | output | N_DOM | Power switch enable, 1 = powered |
| restore | output | N_DOM | Retention restore strobe |
| dom_status | output | 2*N_DOM | Two-bit status per domain, domain i in bits [2i+1:2i] |
| dom_err | output | N_DOM | Sticky acknowledge-timeout flag per domain |
| fault | output | 1 | Sequencer halted on a timeout |

## Verification
A wrong engine state shows up at the ports within a cycle or two. A step out of order appears as a switch edge without isolation, or a restore strobe without power-good. A lost or swapped index shows up as the wrong domain's controls moving, or as a wrong order of switch edges when several requests land in the same cycle. A broken wait or stagger counter shows up as a status change while the acknowledge is still high, as a start that comes too soon after a completion, or as fault arriving early or never on a stuck acknowledge.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

    typedef enum logic [1:0] {
        ST_ON       = 2'd0,
        ST_GOING_DN = 2'd1,
        ST_OFF      = 2'd2,
        ST_GOING_UP = 2'd3
    } dom_stat_e;

    typedef enum logic [2:0] {
        E_IDLE,
        E_GAP,
        E_SAVE,
        E_ISO,
        E_OFF,
        E_ON,
        E_REST,
        E_FAULT
    } eng_state_e;

    typedef enum logic [2:0] {
        C_NONE,
        C_ISO_ON,
        C_SW_OFF,
        C_DONE_DN,
        C_SW_ON,
        C_DONE_UP,
        C_ERR
    } dom_cmd_e;

    // lowest set bit of a vector (0 when empty)
    function automatic int unsigned lowest_idx(input logic [31:0] v);
        int unsigned r;
        r = 0;
        for (int i = 31; i >= 0; i--) begin
            if (v[i]) r = i;
        end
        return r;
    endfunction

    // highest set bit of a vector (0 when empty)
    function automatic int unsigned highest_idx(input logic [31:0] v);
        int unsigned r;
        r = 0;
        for (int i = 0; i < 32; i++) begin
            if (v[i]) r = i;
        end
        return r;
    endfunction

endpackage

// File: rtl/pgs_dom_ctl.sv
module pgs_dom_ctl
    import pgs_pkg::*;
#(
    parameter bit IS_AON = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      req_dn,
    input  logic      req_up,
    input  logic      fault,
    input  logic      sel,
    input  dom_cmd_e  cmd,
    output dom_stat_e status,
    output logic      iso,
    output logic      sw,
    output logic      err
);

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= ST_ON;
            iso    <= 1'b0;
            sw     <= 1'b1;
            err    <= 1'b0;
        end else begin
            // request acceptance only from a stable state
            if (!IS_AON && !fault) begin
                if (status == ST_ON && req_dn)
                    status <= ST_GOING_DN;
                else if (status == ST_OFF && req_up)
                    status <= ST_GOING_UP;
            end
            if (sel) begin
                case (cmd)
                    C_ISO_ON:  iso <= 1'b1;
                    C_SW_OFF:  sw  <= 1'b0;
                    C_DONE_DN: status <= ST_OFF;
                    C_SW_ON:   sw  <= 1'b1;
                    C_DONE_UP: begin
                        iso    <= 1'b0;
                        status <= ST_ON;
                    end
                    C_ERR:     err <= 1'b1;
                    default:   ;
                endcase
            end
        end
    end

endmodule

// File: rtl/pgs_engine.sv
module pgs_engine
    import pgs_pkg::*;
#(
    parameter int N_DOM   = 4,
    parameter int STAGGER = 4,
    parameter int TIMEOUT = 16,
    localparam int IW = (N_DOM > 1) ? $clog2(N_DOM) : 1,
    localparam int GW = $clog2(STAGGER + 2),
    localparam int TW = $clog2(TIMEOUT + 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_DOM-1:0] ack,
    input  logic [N_DOM-1:0] pend_dn,
    input  logic [N_DOM-1:0] pend_up,
    output dom_cmd_e         cmd,
    output logic [IW-1:0]    cmd_idx,
    output logic [N_DOM-1:0] save_vec,
    output logic [N_DOM-1:0] rest_vec,
    output logic             fault
);

    eng_state_e    state, nstate;
    logic [IW-1:0] cur;
    logic [GW-1:0] gap_cnt;
    logic [TW-1:0] wait_cnt;
    logic          tmo;
    logic          cur_ack;

    always_comb begin
        cur_ack = 1'b0;
        for (int i = 0; i < N_DOM; i++) begin
            if (cur == IW'(i)) cur_ack = ack[i];
        end
    end

    assign tmo = (wait_cnt == TW'(TIMEOUT - 1));

    always_comb begin
        nstate  = state;
        cmd     = C_NONE;
        cmd_idx = cur;
        case (state)
            E_IDLE: begin
                if (|pend_dn) begin
                    nstate  = E_SAVE;
                    cmd_idx = IW'(lowest_idx(32'(pend_dn)));
                end else if (|pend_up) begin
                    nstate  = E_ON;
                    cmd     = C_SW_ON;
                    cmd_idx = IW'(highest_idx(32'(pend_up)));
                end
            end
            E_GAP:  if (gap_cnt == '0) nstate = E_IDLE;
            E_SAVE: begin
                cmd    = C_ISO_ON;
                nstate = E_ISO;
            end
            E_ISO: begin
                cmd    = C_SW_OFF;
                nstate = E_OFF;
            end
            E_OFF: begin
                if (!cur_ack) begin
                    cmd    = C_DONE_DN;
                    nstate = E_GAP;
                end else if (tmo) begin
                    cmd    = C_ERR;
                    nstate = E_FAULT;
                end
            end
            E_ON: begin
                if (cur_ack) begin
                    nstate = E_REST;
                end else if (tmo) begin
                    cmd    = C_ERR;
                    nstate = E_FAULT;
                end
            end
            E_REST: begin
                cmd    = C_DONE_UP;
                nstate = E_GAP;
            end
            default: nstate = E_FAULT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= E_IDLE;
            cur      <= '0;
            gap_cnt  <= '0;
            wait_cnt <= '0;
        end else begin
            state <= nstate;
            cur   <= cmd_idx;
            if (nstate != state)
                wait_cnt <= '0;
            else if (state == E_OFF || state == E_ON)
                wait_cnt <= wait_cnt + 1'b1;
            if (nstate == E_GAP && state != E_GAP)
                gap_cnt <= GW'(STAGGER);
            else if (state == E_GAP && gap_cnt != '0)
                gap_cnt <= gap_cnt - 1'b1;
        end
    end

    always_comb begin
        for (int i = 0; i < N_DOM; i++) begin
            save_vec[i] = (state == E_SAVE) && (cur == IW'(i));
            rest_vec[i] = (state == E_REST) && (cur == IW'(i));
        end
    end

    assign fault = (state == E_FAULT);

endmodule

// File: rtl/pgs_top.sv
module pgs_top
    import pgs_pkg::*;
#(
    parameter int               N_DOM    = 4,
    parameter int               STAGGER  = 4,
    parameter int               TIMEOUT  = 16,
    parameter logic [N_DOM-1:0] AON_MASK = 4'b1000,
    localparam int IW = (N_DOM > 1) ? $clog2(N_DOM) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_DOM-1:0]   req_dn,
    input  logic [N_DOM-1:0]   req_up,
    input  logic [N_DOM-1:0]   pwr_ack,
    output logic [N_DOM-1:0]   ret_save,
    output logic [N_DOM-1:0]   iso_en,
    output logic [N_DOM-1:0]   sw_en,
    output logic [N_DOM-1:0]   restore,
    output logic [2*N_DOM-1:0] dom_status,
    output logic [N_DOM-1:0]   dom_err,
    output logic               fault
);

    dom_cmd_e         cmd;
    logic [IW-1:0]    cmd_idx;
    logic [N_DOM-1:0] pend_dn, pend_up;
    dom_stat_e        st [N_DOM];

    pgs_engine #(
        .N_DOM  (N_DOM),
        .STAGGER(STAGGER),
        .TIMEOUT(TIMEOUT)
    ) u_engine (
        .clk     (clk),
        .rst     (rst),
        .ack     (pwr_ack),
        .pend_dn (pend_dn),
        .pend_up (pend_up),
        .cmd     (cmd),
        .cmd_idx (cmd_idx),
        .save_vec(ret_save),
        .rest_vec(restore),
        .fault   (fault)
    );

    for (genvar g = 0; g < N_DOM; g++) begin : g_dom
        pgs_dom_ctl #(
            .IS_AON(AON_MASK[g])
        ) u_dom (
            .clk   (clk),
            .rst   (rst),
            .req_dn(req_dn[g]),
            .req_up(req_up[g]),
            .fault (fault),
            .sel   (cmd_idx == IW'(g)),
            .cmd   (cmd),
            .status(st[g]),
            .iso   (iso_en[g]),
            .sw    (sw_en[g]),
            .err   (dom_err[g])
        );
        assign pend_dn[g]          = (st[g] == ST_GOING_DN);
        assign pend_up[g]          = (st[g] == ST_GOING_UP);
        assign dom_status[2*g +: 2] = st[g];
    end

endmodule

// File: rtl/pgs_chk.sv
module pgs_chk #(
    parameter int               N_DOM    = 4,
    parameter logic [N_DOM-1:0] AON_MASK = 4'b1000
) (
    input logic             clk,
    input logic             rst,
    input logic [N_DOM-1:0] pwr_ack,
    input logic [N_DOM-1:0] ret_save,
    input logic [N_DOM-1:0] iso_en,
    input logic [N_DOM-1:0] sw_en,
    input logic [N_DOM-1:0] restore,
    input logic [N_DOM-1:0] dom_err,
    input logic             fault
);

    AST_ONE_SAVE: assert property (@(posedge clk) disable iff (rst) $onehot0(ret_save | restore)); // R8

    AST_FROZEN_AFTER_FAULT: assert property (@(posedge clk) disable iff (rst)
        (fault && $past(fault)) |-> ($stable(sw_en) && $stable(iso_en))); // R10

    for (genvar i = 0; i < N_DOM; i++) begin : g_chk
        AST_SAVE_THEN_ISO: assert property (@(posedge clk) disable iff (rst)
            $rose(iso_en[i]) |-> $past(ret_save[i])); // R2
        AST_ISO_BEFORE_OFF: assert property (@(posedge clk) disable iff (rst)
            $fell(sw_en[i]) |-> $past(iso_en[i])); // R2
        AST_RESTORE_POWERED: assert property (@(posedge clk) disable iff (rst)
            restore[i] |-> (pwr_ack[i] && sw_en[i] && iso_en[i])); // R4
        AST_ISO_AFTER_RESTORE: assert property (@(posedge clk) disable iff (rst)
            $fell(iso_en[i]) |-> $past(restore[i])); // R4
        AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
            $past(dom_err[i]) |-> dom_err[i]); // R10
        if (AON_MASK[i]) begin : g_aon
            AST_AON_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
                (sw_en[i] && !iso_en[i] && !ret_save[i])); // R6
        end
    end

endmodule

bind pgs_top pgs_chk #(
    .N_DOM   (N_DOM),
    .AON_MASK(AON_MASK)
) u_pgs_chk (
    .clk     (clk),
    .rst     (rst),
    .pwr_ack (pwr_ack),
    .ret_save(ret_save),
    .iso_en  (iso_en),
    .sw_en   (sw_en),
    .restore (restore),
    .dom_err (dom_err),
    .fault   (fault)
);

// File: tb/test_pgs_top.sv
module test_pgs_top;

    localparam int CLK_PERIOD = 10;
    localparam int NDOM    = 4;
    localparam int STAGGER = 4;
    localparam int TIMEOUT = 16;
    localparam int ACK_DLY = 3;
    localparam int WD_CYC  = 20000;

    logic            clk = 1'b0;
    logic            rst;
    logic [NDOM-1:0] req_dn, req_up, pwr_ack;
    logic [NDOM-1:0] ret_save, iso_en, sw_en, restore, dom_err;
    logic [2*NDOM-1:0] dom_status;
    logic            fault;

    logic [NDOM-1:0]    stuck;
    logic [ACK_DLY-1:0] pipe [NDOM];

    int checks = 0;
    int bad    = 0;
    int cyc    = 0;
    int save_cnt = 0;
    int rest_cnt = 0;
    int done_cyc = -1000;
    int dn_ord [8];
    int up_ord [8];
    int n_dn = 0;
    int n_up = 0;
    int save_cyc [NDOM];
    int rest_cyc [NDOM];
    logic [NDOM-1:0]   p_iso, p_sw;
    logic [2*NDOM-1:0] p_st;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgs_top #(
        .N_DOM   (NDOM),
        .STAGGER (STAGGER),
        .TIMEOUT (TIMEOUT),
        .AON_MASK(4'b1000)
    ) i_pgs_top (
        .clk       (clk),
        .rst       (rst),
        .req_dn    (req_dn),
        .req_up    (req_up),
        .pwr_ack   (pwr_ack),
        .ret_save  (ret_save),
        .iso_en    (iso_en),
        .sw_en     (sw_en),
        .restore   (restore),
        .dom_status(dom_status),
        .dom_err   (dom_err),
        .fault     (fault)
    );

    // domain acknowledge model: follows switch enable after ACK_DLY cycles
    always @(posedge clk) begin
        for (int i = 0; i < NDOM; i++) begin
            if (rst) begin
                pipe[i]    <= '1;
                pwr_ack[i] <= 1'b1;
            end else begin
                pipe[i] <= {pipe[i][ACK_DLY-2:0], sw_en[i]};
                if (!stuck[i]) pwr_ack[i] <= pipe[i][ACK_DLY-1];
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int st_of(input int i);
        return int'(dom_status[2*i +: 2]);
    endfunction

    // event monitor, sampled away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            for (int i = 0; i < NDOM; i++) begin
                if (ret_save[i]) begin
                    save_cnt++;
                    save_cyc[i] = cyc;
                    chk(sw_en[i] && !iso_en[i], "R2 save while powered", int'({sw_en[i], iso_en[i]}), 2);
                    chk(cyc - done_cyc >= STAGGER + 1, "R9 stagger before save", cyc - done_cyc, STAGGER + 1);
                end
                if (iso_en[i] && !p_iso[i])
                    chk(save_cyc[i] == cyc - 1, "R2 iso after save", cyc - save_cyc[i], 1);
                if (!sw_en[i] && p_sw[i]) begin
                    chk(p_iso[i] && iso_en[i], "R2 iso before switch off", int'(p_iso[i]), 1);
                    if (n_dn < 8) dn_ord[n_dn] = i;
                    n_dn++;
                end
                if (sw_en[i] && !p_sw[i]) begin
                    if (n_up < 8) up_ord[n_up] = i;
                    n_up++;
                    chk(cyc - done_cyc >= STAGGER + 1, "R9 stagger before switch on", cyc - done_cyc, STAGGER + 1);
                end
                if (restore[i]) begin
                    rest_cnt++;
                    rest_cyc[i] = cyc;
                    chk(pwr_ack[i] && sw_en[i], "R4 restore only when powered", int'({pwr_ack[i], sw_en[i]}), 3);
                end
                if (!iso_en[i] && p_iso[i]) begin
                    chk(rest_cyc[i] == cyc - 1, "R4 iso release after restore", cyc - rest_cyc[i], 1);
                    chk(st_of(i) == 0, "R4 status ON at release", st_of(i), 0);
                end
                if (st_of(i) == 2 && p_st[2*i +: 2] == 2'd1) begin
                    chk(!pwr_ack[i], "R3 OFF only after ack low", int'(pwr_ack[i]), 0);
                    done_cyc = cyc;
                end
                if (st_of(i) == 0 && p_st[2*i +: 2] == 2'd3)
                    done_cyc = cyc;
            end
        end
        p_iso = iso_en;
        p_sw  = sw_en;
        p_st  = dom_status;
    end

    task automatic settle(input string req);
        int n;
        bit busy;
        n = 0;
        @(negedge clk);
        do begin
            busy = 1'b0;
            for (int i = 0; i < NDOM; i++) if (st_of(i) == 1 || st_of(i) == 3) busy = 1'b1;
            if (busy) @(negedge clk);
            n++;
        end while (busy && n < 400);
        chk(!busy, req, n, 0);
        repeat (STAGGER + 4) @(negedge clk);
    endtask

    task automatic pulse(input logic [NDOM-1:0] dn, input logic [NDOM-1:0] up);
        req_dn = dn;
        req_up = up;
        @(negedge clk);
        req_dn = '0;
        req_up = '0;
    endtask

    task automatic check_reset(input string tag);
        for (int i = 0; i < NDOM; i++)
            chk(st_of(i) == 0 && sw_en[i] && !iso_en[i] && !dom_err[i], tag, st_of(i), 0);
        chk(!fault, tag, int'(fault), 0);
    endtask

    typedef struct packed {
        logic [1:0] dom;
        logic       dn;
        logic [1:0] exp_st;
        logic [1:0] exp_save;
        logic [1:0] exp_rest;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 1'b1, 2'd2, 2'd1, 2'd0},  // R2 R3 power down d0
        '{2'd0, 1'b1, 2'd2, 2'd0, 2'd0},  // R7 down on OFF domain ignored
        '{2'd0, 1'b0, 2'd0, 2'd0, 2'd1},  // R4 power up d0
        '{2'd3, 1'b1, 2'd0, 2'd0, 2'd0},  // R6 always-on domain ignores request
        '{2'd2, 1'b1, 2'd2, 2'd1, 2'd0},  // R2 power down d2
        '{2'd2, 1'b0, 2'd0, 2'd0, 2'd1},  // R4 power up d2
        '{2'd1, 1'b0, 2'd0, 2'd0, 2'd0}   // R7 up on ON domain ignored
    };

    initial begin
        repeat (WD_CYC) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=0", WD_CYC);
        $display("test done: total=%0d bad=%0d", checks + 1, bad);
        $finish;
    end

    initial begin
        int s0, r0;
        rst = 1'b1;
        req_dn = '0;
        req_up = '0;
        stuck = '0;
        for (int i = 0; i < NDOM; i++) begin
            save_cyc[i] = -100;
            rest_cyc[i] = -100;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_reset("R1 reset state");

        // table walk
        for (int v = 0; v < NV; v++) begin
            logic [NDOM-1:0] m;
            m = NDOM'(1) << VEC[v].dom;
            s0 = save_cnt;
            r0 = rest_cnt;
            pulse(VEC[v].dn ? m : '0, VEC[v].dn ? '0 : m);
            settle("R3 R4 sequence completes");
            chk(st_of(int'(VEC[v].dom)) == int'(VEC[v].exp_st), "R5 R6 R7 final status",
                st_of(int'(VEC[v].dom)), int'(VEC[v].exp_st));
            chk(sw_en[VEC[v].dom] == (VEC[v].exp_st == 2'd0), "R2 R4 switch level",
                int'(sw_en[VEC[v].dom]), int'(VEC[v].exp_st == 2'd0));
            chk(save_cnt - s0 == int'(VEC[v].exp_save), "R6 R7 save strobes", save_cnt - s0, int'(VEC[v].exp_save));
            chk(rest_cnt - r0 == int'(VEC[v].exp_rest), "R4 R7 restore strobes", rest_cnt - r0, int'(VEC[v].exp_rest));
        end

        // R5: transition code visible one cycle after request; R7: opposite request mid-transition ignored
        req_dn = 4'b0010;
        @(negedge clk);
        req_dn = '0;
        chk(st_of(1) == 1, "R5 GOING_DOWN code", st_of(1), 1);
        req_up = 4'b0010;
        @(negedge clk);
        req_up = '0;
        settle("R7 settle");
        chk(st_of(1) == 2, "R7 up during transition ignored", st_of(1), 2);
        req_up = 4'b0010;
        @(negedge clk);
        req_up = '0;
        chk(st_of(1) == 3, "R5 GOING_UP code", st_of(1), 3);
        settle("R4 settle");
        chk(st_of(1) == 0, "R4 back ON", st_of(1), 0);

        // R8: ordering of simultaneous requests
        n_dn = 0;
        pulse(4'b0111, '0);
        settle("R8 settle down");
        chk(n_dn == 3, "R8 down count", n_dn, 3);
        chk(dn_ord[0] == 0 && dn_ord[1] == 1 && dn_ord[2] == 2, "R8 ascending down order",
            dn_ord[0] * 100 + dn_ord[1] * 10 + dn_ord[2], 12);
        n_up = 0;
        pulse('0, 4'b0111);
        settle("R8 settle up");
        chk(n_up == 3, "R8 up count", n_up, 3);
        chk(up_ord[0] == 2 && up_ord[1] == 1 && up_ord[2] == 0, "R8 descending up order",
            up_ord[0] * 100 + up_ord[1] * 10 + up_ord[2], 210);

        // R10: stuck acknowledge leads to timeout fault
        stuck = 4'b0010;
        pulse(4'b0010, '0);
        repeat (TIMEOUT + 12) @(negedge clk);
        chk(dom_err == 4'b0010, "R10 error flag", int'(dom_err), 2);
        chk(fault, "R10 fault", int'(fault), 1);
        s0 = save_cnt;
        pulse(4'b0001, '0);
        repeat (20) @(negedge clk);
        chk(st_of(0) == 0 && sw_en[0] && !iso_en[0], "R10 request ignored after fault", st_of(0), 0);
        chk(save_cnt == s0, "R10 no activity after fault", save_cnt - s0, 0);
        chk(dom_err == 4'b0010, "R10 error sticky", int'(dom_err), 2);

        // R1 again after reset out of fault
        stuck = '0;
        rst = 1'b1;
        repeat (ACK_DLY + 3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_reset("R1 reset clears fault");

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule